// File: doc/BRIEF.md
# Resource-Class Issue Rule Checker

This block decides, every cycle, how many of the oldest instructions in a small decode buffer can go to the functional units together. Each buffer slot holds a valid bit and a class code. All instructions of one class compete for the same pool of units, so the decision is made over classes, not over individual opcodes. Each class has a unit count, set by a module parameter. A group of instructions is issuable when, for every class, the number of its members in the group does not exceed that class's unit count. Because only these per-class tallies matter, the order of instructions inside a group never changes whether the group fits, and one class may appear several times in a group.

The block looks at every leading prefix of the buffer at once: all slots, then one fewer, and so on down to a single slot. It reports the longest prefix that fits. An invalid slot ends the usable prefix. When not even the oldest instruction fits, the block reports zero. Its outputs are a one-hot issue-count vector and the binary count. Both are registered on the rising clock edge. Slot 0 is the oldest slot. The class code of slot i occupies bits [i*CLS_W +: CLS_W] of the class bus.

With the default parameters there are four slots and four classes with 2-bit codes. Class 0 is the arithmetic group (add, subtract, compare) and has 2 units. Class 1 is the memory group and has 1 unit. Class 2 has 0 units. Class 3 has 4 units.

Top module: `issue_rule_checker`

## Requirements
- R1: While rst is high at a rising edge, after that edge issue_onehot and issue_count are both all zeros.
- R2: issue_count equals the largest L (0 to SLOTS) such that slots 0..L-1 are all valid and, for every class c, the number of those L slots whose class code is c is at most the unit count of c (defaults: class 0 = 2, class 1 = 1, class 2 = 0, class 3 = 4).
- R3: Whether a fully valid buffer issues all SLOTS instructions does not depend on the order of the class codes in the slots; reversing the slot order gives the same all-or-not answer.
- R4: A class may appear repeatedly in an issued group up to its unit count. With defaults, four class-3 slots issue 4, and three class-0 slots followed by a class-3 slot issue 2.
- R5: The first invalid slot ends the prefix. Valid slots after it are never counted, so with valid pattern 4'b1011 the count is at most 2.
- R6: If slot 0 is invalid, or its class has zero units, the count is 0 and issue_onehot equals 1 (bit 0 set).
- R7: Outside reset-cleared cycles, exactly one bit of issue_onehot is set, and it is bit issue_count.
- R8: Outputs change only at a rising edge and reflect the inputs sampled at that edge; between edges they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | SLOTS | Valid bit per slot, bit 0 is the oldest slot |
| slot_class | input | SLOTS*CLS_W | Class code per slot, slot i at [i*CLS_W +: CLS_W] |
| issue_onehot | output | SLOTS+1 | Bit n set when n instructions issue |
| issue_count | output | CNT_W | Number of leading instructions issued |

## Verification
The bench sweeps every valid pattern against every class tuple. It computes the expected count by walking the slots one at a time and stopping at the first invalid slot or the first unit overrun. A design that ignored invalid slots in the middle would issue past a hole. A design that compared only the full group, or only pairs, would report too many or too few instructions when a class overruns partway through. The bench also checks that a zero-unit class at slot 0 forces a zero issue, where an off-by-one in the unit compare would let a single instruction through. Reversed tuples check that full-group fit ignores slot order. A mid-cycle input change checks that a design passing inputs straight through to the outputs would be caught.

// File: rtl/issue_pkg.sv
package issue_pkg;

  // Number of consecutive ones starting at bit 0, looking at n bits.
  function automatic int unsigned lead_ones(input logic [31:0] v, input int n);
    int unsigned r;
    bit          stop;
    r    = 0;
    stop = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (i < n && !stop) begin
        if (v[i]) r++;
        else      stop = 1'b1;
      end
    end
    return r;
  endfunction

  // Index of the highest set bit at or below n, zero when none.
  function automatic int unsigned highest_set(input logic [31:0] v, input int n);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (i <= n && v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/class_demand.sv
module class_demand #(
  parameter int SLOTS   = 4,
  parameter int CLASSES = 4,
  parameter int CLS_W   = 2,
  parameter int CNT_W   = 3,
  parameter int PLEN    = 1
) (
  input  logic [SLOTS*CLS_W-1:0]   slot_class,
  output logic [CLASSES*CNT_W-1:0] demand
);

  // Per-class tally over the first PLEN slots.
  always_comb begin
    demand = '0;
    for (int c = 0; c < CLASSES; c++) begin
      for (int s = 0; s < PLEN; s++) begin
        if (slot_class[s*CLS_W +: CLS_W] == CLS_W'(c))
          demand[c*CNT_W +: CNT_W] = demand[c*CNT_W +: CNT_W] + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/prefix_fit_check.sv
module prefix_fit_check #(
  parameter int CLASSES = 4,
  parameter int CNT_W   = 3,
  parameter int PLEN    = 1,
  parameter logic [CLASSES*CNT_W-1:0] UNIT_CNT = '0
) (
  input  logic [CLASSES*CNT_W-1:0] demand,
  input  logic [CNT_W-1:0]         valid_len,
  output logic                     fits
);

  always_comb begin
    fits = (valid_len >= CNT_W'(PLEN));
    for (int c = 0; c < CLASSES; c++) begin
      if (demand[c*CNT_W +: CNT_W] > UNIT_CNT[c*CNT_W +: CNT_W])
        fits = 1'b0;
    end
  end

endmodule

// File: rtl/issue_pick.sv
module issue_pick
  import issue_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int CNT_W = 3
) (
  input  logic [SLOTS:1]   fit_vec,
  output logic [SLOTS:0]   pick_onehot,
  output logic [CNT_W-1:0] pick_count
);

  assign pick_count = CNT_W'(highest_set(32'({fit_vec, 1'b0}), SLOTS));

  always_comb begin
    pick_onehot = '0;
    pick_onehot[pick_count] = 1'b1;
  end

endmodule

// File: rtl/issue_rule_checker.sv
module issue_rule_checker
  import issue_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int CLASSES = 4,
  parameter int CLS_W   = $clog2(CLASSES),
  parameter int CNT_W   = $clog2(SLOTS + 1),
  parameter logic [CLASSES*CNT_W-1:0] UNIT_CNT = {3'd4, 3'd0, 3'd1, 3'd2}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SLOTS-1:0]       slot_valid,
  input  logic [SLOTS*CLS_W-1:0] slot_class,
  output logic [SLOTS:0]         issue_onehot,
  output logic [CNT_W-1:0]       issue_count
);

  logic [CNT_W-1:0] valid_len;
  logic [SLOTS:1]   prefix_fit;
  logic [SLOTS:0]   next_onehot;
  logic [CNT_W-1:0] next_count;

  assign valid_len = CNT_W'(lead_ones(32'(slot_valid), SLOTS));

  for (genvar p = 1; p <= SLOTS; p++) begin : g_prefix
    logic [CLASSES*CNT_W-1:0] demand;

    class_demand #(
      .SLOTS(SLOTS), .CLASSES(CLASSES), .CLS_W(CLS_W), .CNT_W(CNT_W), .PLEN(p)
    ) u_demand (
      .slot_class(slot_class),
      .demand    (demand)
    );

    prefix_fit_check #(
      .CLASSES(CLASSES), .CNT_W(CNT_W), .PLEN(p), .UNIT_CNT(UNIT_CNT)
    ) u_fit (
      .demand   (demand),
      .valid_len(valid_len),
      .fits     (prefix_fit[p])
    );
  end

  issue_pick #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_pick (
    .fit_vec    (prefix_fit),
    .pick_onehot(next_onehot),
    .pick_count (next_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_onehot <= '0;
      issue_count  <= '0;
    end else begin
      issue_onehot <= next_onehot;
      issue_count  <= next_count;
    end
  end

endmodule

// File: rtl/issue_rule_checker_sva.sv
module issue_rule_checker_sva #(
  parameter int SLOTS   = 4,
  parameter int CLASSES = 4,
  parameter int CLS_W   = 2,
  parameter int CNT_W   = 3,
  parameter logic [CLASSES*CNT_W-1:0] UNIT_CNT = '0
) (
  input logic                   clk,
  input logic                   rst,
  input logic [SLOTS-1:0]       slot_valid,
  input logic [SLOTS*CLS_W-1:0] slot_class,
  input logic [SLOTS:0]         issue_onehot,
  input logic [CNT_W-1:0]       issue_count,
  input logic [CNT_W-1:0]       valid_len,
  input logic [SLOTS:1]         prefix_fit
);

  logic [CNT_W-1:0] head_units;
  assign head_units = UNIT_CNT[slot_class[CLS_W-1:0]*CNT_W +: CNT_W];

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (issue_onehot == '0 && issue_count == '0));

  a_r7_onehot0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issue_onehot));

  a_r7_exactly_one: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($onehot(issue_onehot) && issue_onehot[issue_count]));

  a_r5_within_valid: assert property (@(posedge clk) disable iff (rst)
    !rst |=> issue_count <= $past(valid_len));

  a_r6_zero_head: assert property (@(posedge clk) disable iff (rst)
    (!slot_valid[0] || head_units == '0) |=> issue_onehot[0]);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    ($stable(slot_valid) && $stable(slot_class) && !$past(rst)) |=> $stable(issue_count));

  for (genvar p = 2; p <= SLOTS; p++) begin : g_mono
    // R2: a fitting prefix implies every shorter prefix fits
    a_r2_prefix_monotone: assert property (@(posedge clk) disable iff (rst)
      prefix_fit[p] |-> prefix_fit[p-1]);
  end

endmodule

bind issue_rule_checker issue_rule_checker_sva #(
  .SLOTS(SLOTS), .CLASSES(CLASSES), .CLS_W(CLS_W), .CNT_W(CNT_W), .UNIT_CNT(UNIT_CNT)
) chk_i (
  .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_class(slot_class),
  .issue_onehot(issue_onehot), .issue_count(issue_count),
  .valid_len(valid_len), .prefix_fit(prefix_fit)
);

// File: tb/issue_rule_checker_tb.sv
module issue_rule_checker_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] slot_valid = '0;
  logic [7:0] slot_class = '0;
  logic [4:0] issue_onehot;
  logic [2:0] issue_count;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;
  int units [4] = '{2, 1, 0, 4};

  always #5 clk = ~clk;

  issue_rule_checker dut_i (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_class(slot_class),
    .issue_onehot(issue_onehot), .issue_count(issue_count)
  );

  // Sequential walk: take slots one by one until a hole or an overrun.
  function automatic int model_count(input logic [3:0] v, input logic [7:0] cls);
    int tally [4];
    int n;
    bit stop;
    tally = '{0, 0, 0, 0};
    n = 0;
    stop = 1'b0;
    for (int s = 0; s < 4; s++) begin
      int c;
      c = int'(cls[s*2 +: 2]);
      if (!stop) begin
        if (!v[s] || tally[c] + 1 > units[c]) stop = 1'b1;
        else begin
          tally[c]++;
          n++;
        end
      end
    end
    return n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] v, input logic [7:0] cls);
    @(negedge clk);
    slot_valid = v;
    slot_class = cls;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int a;
    int b;
    // R1: reset clears outputs
    repeat (3) @(posedge clk);
    #1;
    check("R1 onehot", int'(issue_onehot), 0);
    check("R1 count", int'(issue_count), 0);
    @(negedge clk);
    rst = 1'b0;

    // R2 / R7: exhaustive sweep
    for (int v = 0; v < 16; v++) begin
      for (int c = 0; c < 256; c++) begin
        int e;
        step(4'(v), 8'(c));
        e = model_count(4'(v), 8'(c));
        check("R2 count", int'(issue_count), e);
        check("R7 onehot", int'(issue_onehot), 1 << e);
      end
    end

    // R3: full-group fit independent of slot order
    for (int c = 0; c < 256; c++) begin
      logic [7:0] t;
      logic [7:0] r;
      t = 8'(c);
      r = {t[1:0], t[3:2], t[5:4], t[7:6]};
      step(4'hF, t);
      a = int'(issue_count == 3'd4);
      step(4'hF, r);
      b = int'(issue_count == 3'd4);
      check("R3 order", b, a);
    end

    // R4: repeated classes
    step(4'hF, {2'd3, 2'd3, 2'd3, 2'd3});
    check("R4 four class3", int'(issue_count), 4);
    step(4'hF, {2'd3, 2'd0, 2'd0, 2'd0});
    check("R4 three class0", int'(issue_count), 2);
    step(4'hF, {2'd3, 2'd0, 2'd1, 2'd0});
    check("R4 alu pair plus mem", int'(issue_count), 4);

    // R5: hole ends prefix
    step(4'b1011, {2'd3, 2'd3, 2'd3, 2'd3});
    check("R5 hole", int'(issue_count), 2);
    step(4'b1110, {2'd3, 2'd3, 2'd3, 2'd3});
    check("R5 head invalid", int'(issue_count), 0);

    // R6: zero-unit class at head
    step(4'hF, {2'd3, 2'd3, 2'd3, 2'd2});
    check("R6 count", int'(issue_count), 0);
    check("R6 onehot", int'(issue_onehot), 1);

    // R8: outputs hold between edges
    step(4'hF, {2'd3, 2'd3, 2'd3, 2'd3});
    @(negedge clk);
    slot_valid = 4'h0;
    #2;
    check("R8 hold", int'(issue_count), 4);
    @(posedge clk);
    #1;
    check("R8 update", int'(issue_count), 0);

    // R1: reset mid-run
    step(4'hF, {2'd3, 2'd3, 2'd3, 2'd3});
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid onehot", int'(issue_onehot), 0);
    check("R1 mid count", int'(issue_count), 0);

    finish_run();
  end

endmodule